// File: doc/BRIEF.md
# SD Host Block Transfer Sequencer

This block sits between the host-facing control registers of an SD host controller and its data path. When software writes the transfer control word together with a block count, the sequencer works out which kind of data transfer the command starts: none, a single block, a counted run of blocks, or an open-ended run. It latches the direction, the command index and the expected response format. It then follows the transfer by counting block-complete strobes from the data-line shifter.

For a counted run it decrements the remaining count on each strobe. When the count reaches zero it pulses a done flag. If automatic stop is enabled, it then asks the command serializer for a stop command. An open-ended run continues until the abort input ends it. A DMA start pulse is produced in the same cycle as an accepted write that has DMA enabled. While a transfer or a stop request is outstanding, the block reports busy and ignores new control writes.

The stop request follows a valid/ready handshake. Once `stop_valid` rises it stays high, and the block stays busy, until the serializer asserts `stop_ready` while `stop_valid` is high. The request completes on that clock edge. The serializer may hold `stop_ready` low for any number of cycles.

Top module: `sd_xfer_seq`

## Requirements
- R1: An accepted write latches the control word and sets the reported direction. A write is accepted when `cmd_wr` is high while not busy. The control word fields are: bits [1:0] response select, bit 2 multi-block, bit 3 direction (1 = card to host, 0 = host to card), bit 4 auto-stop enable, bit 5 count enable, bit 6 DMA enable and bits [12:7] command index. The latched values appear after the accepting edge on `xfer_dir_rd` and `cmd_index`.
- R2: The latched response select is decoded as follows: 0 gives `resp_bits`=0, 1 gives 136, 2 gives 48 and 3 gives 48. `resp_busy` is high only for select 3.
- R3: `xfer_kind` is coded 0 none, 1 single, 2 counted multi, 3 infinite. Multi-block 0 always gives single. Multi-block 1 with count enable 0 gives infinite. Multi-block 1 with count enable 1 gives none if the block count is zero, and counted multi otherwise.
- R4: For a counted multi transfer, `blk_left` loads the block count and drops by one on each `blk_done`. On the edge that takes it to zero, `done` goes high for one cycle.
- R5: A single transfer pulses `done` for one cycle after its first `blk_done` and then returns to not busy. A transfer of kind none pulses `done` right after the accepting edge and never becomes busy.
- R6: A counted multi transfer with auto-stop enabled raises `stop_valid` together with `done`. `stop_valid` and `busy` are then held until a cycle in which `stop_ready` is high.
- R7: Auto-stop enable has no effect on single transfers, infinite transfers or counted transfers that end without it. None of these raises `stop_valid`.
- R8: `dma_start` is high, combinationally, during the cycle of an accepted write that has DMA enable set. It stays low for writes made while busy.
- R9: An infinite transfer stays busy through any number of `blk_done` strobes and never pulses `done`. `abort` returns it to not busy without a stop request.
- R10: A write made while busy changes none of `xfer_kind`, `xfer_dir_rd` or `blk_left`.
- R11: If `abort` and the final `blk_done` arrive in the same cycle, abort wins. The block goes to not busy with no `done` pulse and no stop request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_wr | input | 1 | Control word write strobe (command index write) |
| cmd_word | input | 13 | Transfer control word |
| blk_cnt_in | input | CNT_W | Block count written with the control word |
| blk_done | input | 1 | One block finished on the data lines |
| abort | input | 1 | Ends the active transfer |
| stop_ready | input | 1 | Serializer accepts the stop request |
| stop_valid | output | 1 | Automatic stop command requested |
| dma_start | output | 1 | DMA start pulse |
| done | output | 1 | Transfer complete pulse |
| busy | output | 1 | Transfer or stop request outstanding |
| xfer_kind | output | 2 | Latched transfer kind |
| xfer_dir_rd | output | 1 | Latched direction, 1 = read |
| cmd_index | output | 6 | Latched command index |
| resp_bits | output | 8 | Expected response length in bits |
| resp_busy | output | 1 | Busy check expected after response |
| blk_left | output | CNT_W | Blocks remaining in a counted transfer |

## Verification
The final block-complete strobe and an abort can land in the same cycle. The bench provokes this with a one-block counted transfer that has auto-stop enabled, raising both inputs on one edge. It judges the result by requiring no done pulse, no stop request and a return to not busy. A second coincidence is a control write arriving while a transfer is running. The bench makes that write with DMA enabled and different fields, then confirms that the latched kind, direction, remaining count and the DMA pulse are all untouched.

// File: rtl/sd_xfer_pkg.sv
package sd_xfer_pkg;
  localparam int CTRL_W = 13;
  localparam int IDX_W  = 6;

  typedef enum logic [1:0] {
    KIND_NONE   = 2'd0,
    KIND_SINGLE = 2'd1,
    KIND_MULTI  = 2'd2,
    KIND_INF    = 2'd3
  } xfer_kind_e;

  typedef enum logic [1:0] {
    RSP_NONE       = 2'd0,
    RSP_LONG       = 2'd1,
    RSP_SHORT      = 2'd2,
    RSP_SHORT_BUSY = 2'd3
  } rsp_sel_e;

  typedef struct packed {
    logic [IDX_W-1:0] cmd_idx;
    logic             dma_en;
    logic             cnt_en;
    logic             auto_stop;
    logic             dir_rd;
    logic             multi;
    rsp_sel_e         rsp;
  } ctrl_word_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_STOP = 2'd2
  } seq_state_e;
endpackage

// File: rtl/sd_xfer_classify.sv
module sd_xfer_classify
  import sd_xfer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             multi,
  input  logic             cnt_en,
  input  logic [CNT_W-1:0] count,
  output xfer_kind_e       kind
);
  always_comb begin
    if (!multi)
      kind = KIND_SINGLE;
    else if (!cnt_en)
      kind = KIND_INF;
    else if (count == '0)
      kind = KIND_NONE;
    else
      kind = KIND_MULTI;
  end
endmodule

// File: rtl/sd_rsp_decode.sv
module sd_rsp_decode
  import sd_xfer_pkg::*;
#(
  parameter int LONG_BITS  = 136,
  parameter int SHORT_BITS = 48,
  parameter int LEN_W      = 8
) (
  input  rsp_sel_e         sel,
  output logic [LEN_W-1:0] len_bits,
  output logic             busy_chk
);
  always_comb begin
    busy_chk = 1'b0;
    unique case (sel)
      RSP_NONE:  len_bits = '0;
      RSP_LONG:  len_bits = LEN_W'(LONG_BITS);
      RSP_SHORT: len_bits = LEN_W'(SHORT_BITS);
      default: begin
        len_bits = LEN_W'(SHORT_BITS);
        busy_chk = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/sd_blk_counter.sv
module sd_blk_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec,
  output logic [CNT_W-1:0] cnt,
  output logic             last
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n)
      cnt <= '0;
    else if (load)
      cnt <= load_val;
    else if (dec && cnt != '0)
      cnt <= cnt - ONE;
  end

  assign last = (cnt == ONE);

  // R4
  cnt_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && !load && cnt != '0) |=> (cnt == $past(cnt) - ONE));
endmodule

// File: rtl/sd_stop_req.sv
module sd_stop_req (
  input  logic clk,
  input  logic rst_n,
  input  logic raise,
  input  logic ready,
  output logic valid
);
  always_ff @(posedge clk) begin
    if (!rst_n)
      valid <= 1'b0;
    else if (raise)
      valid <= 1'b1;
    else if (valid && ready)
      valid <= 1'b0;
  end

  // R6
  stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !ready) |=> valid);
endmodule

// File: rtl/sd_xfer_seq.sv
module sd_xfer_seq
  import sd_xfer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cmd_wr,
  input  logic [CTRL_W-1:0]     cmd_word,
  input  logic [CNT_W-1:0]      blk_cnt_in,
  input  logic                  blk_done,
  input  logic                  abort,
  input  logic                  stop_ready,
  output logic                  stop_valid,
  output logic                  dma_start,
  output logic                  done,
  output logic                  busy,
  output logic [1:0]            xfer_kind,
  output logic                  xfer_dir_rd,
  output logic [IDX_W-1:0]      cmd_index,
  output logic [7:0]            resp_bits,
  output logic                  resp_busy,
  output logic [CNT_W-1:0]      blk_left
);
  ctrl_word_t word;
  xfer_kind_e kind_w, kind_q;
  seq_state_e state;
  rsp_sel_e   rsp_q;
  logic       auto_q, done_q, accept, cnt_last, blk_ev, multi_dec, stop_raise;

  assign word   = ctrl_word_t'(cmd_word);
  assign accept = cmd_wr && (state == ST_IDLE);
  assign blk_ev = (state == ST_RUN) && blk_done && !abort;
  assign multi_dec  = blk_ev && (kind_q == KIND_MULTI);
  assign stop_raise = multi_dec && cnt_last && auto_q;

  sd_xfer_classify #(.CNT_W(CNT_W)) u_classify (
    .multi  (word.multi),
    .cnt_en (word.cnt_en),
    .count  (blk_cnt_in),
    .kind   (kind_w)
  );

  sd_rsp_decode u_rsp (
    .sel      (rsp_q),
    .len_bits (resp_bits),
    .busy_chk (resp_busy)
  );

  sd_blk_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept),
    .load_val ((kind_w == KIND_MULTI) ? blk_cnt_in : '0),
    .dec      (multi_dec),
    .cnt      (blk_left),
    .last     (cnt_last)
  );

  sd_stop_req u_stop (
    .clk   (clk),
    .rst_n (rst_n),
    .raise (stop_raise),
    .ready (stop_ready),
    .valid (stop_valid)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      kind_q      <= KIND_NONE;
      rsp_q       <= RSP_NONE;
      auto_q      <= 1'b0;
      xfer_dir_rd <= 1'b0;
      cmd_index   <= '0;
      done_q      <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (accept) begin
            kind_q      <= kind_w;
            rsp_q       <= word.rsp;
            auto_q      <= word.auto_stop;
            xfer_dir_rd <= word.dir_rd;
            cmd_index   <= word.cmd_idx;
            if (kind_w == KIND_NONE)
              done_q <= 1'b1;
            else
              state <= ST_RUN;
          end
        end
        ST_RUN: begin
          if (abort) begin
            state <= ST_IDLE;
          end else if (blk_done) begin
            unique case (kind_q)
              KIND_SINGLE: begin
                done_q <= 1'b1;
                state  <= ST_IDLE;
              end
              KIND_MULTI: begin
                if (cnt_last) begin
                  done_q <= 1'b1;
                  state  <= auto_q ? ST_STOP : ST_IDLE;
                end
              end
              default: ;
            endcase
          end
        end
        default: begin
          if (stop_valid && stop_ready)
            state <= ST_IDLE;
        end
      endcase
    end
  end

  assign busy      = (state != ST_IDLE);
  assign done      = done_q;
  assign xfer_kind = kind_q;
  assign dma_start = accept && word.dma_en;

  // R8
  dma_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dma_start |-> !busy);

  // R10
  busy_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd_wr) |=> ($stable(xfer_kind) && $stable(xfer_dir_rd)));

  // R7
  stop_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_valid |-> (xfer_kind == 2'd2));

  // R9
  inf_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && xfer_kind == 2'd3 && !abort) |=> (busy && !done));

  // R11
  abort_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !stop_valid && abort) |=> (!done && !stop_valid && !busy));

  // R4
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy || stop_valid));
endmodule

// File: tb/sd_xfer_seq_test.sv
module sd_xfer_seq_test;
  localparam int CNT_W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_wr = 1'b0;
  logic [12:0] cmd_word = '0;
  logic [CNT_W-1:0] blk_cnt_in = '0;
  logic blk_done = 1'b0, abort = 1'b0, stop_ready = 1'b0;
  logic stop_valid, dma_start, done, busy, xfer_dir_rd, resp_busy;
  logic [1:0] xfer_kind;
  logic [5:0] cmd_index;
  logic [7:0] resp_bits;
  logic [CNT_W-1:0] blk_left;

  int tests = 0;
  int fails = 0;

  always #5 clk = ~clk;

  sd_xfer_seq #(.CNT_W(CNT_W)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_word(cmd_word),
    .blk_cnt_in(blk_cnt_in), .blk_done(blk_done), .abort(abort),
    .stop_ready(stop_ready), .stop_valid(stop_valid), .dma_start(dma_start),
    .done(done), .busy(busy), .xfer_kind(xfer_kind), .xfer_dir_rd(xfer_dir_rd),
    .cmd_index(cmd_index), .resp_bits(resp_bits), .resp_busy(resp_busy),
    .blk_left(blk_left)
  );

  function automatic logic [12:0] mk(int idx, bit dma, bit cnten, bit autos,
                                     bit dir, bit multi, int rsp);
    return {idx[5:0], dma, cnten, autos, dir, multi, rsp[1:0]};
  endfunction

  task automatic check(string tag, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic write_cmd(logic [12:0] w, int cnt, int exp_dma, string tag);
    cmd_word = w; blk_cnt_in = cnt[CNT_W-1:0]; cmd_wr = 1'b1;
    #1 check(tag, dma_start, exp_dma);
    @(negedge clk);
    cmd_wr = 1'b0;
  endtask

  task automatic pulse(bit blk, bit abt);
    blk_done = blk; abort = abt;
    @(negedge clk);
    blk_done = 1'b0; abort = 1'b0;
  endtask

  task automatic t_reset;
    check("R1 reset busy", busy, 0);
    check("R4 reset done", done, 0);
    check("R6 reset stop_valid", stop_valid, 0);
    check("R4 reset blk_left", blk_left, 0);
  endtask

  task automatic t_resp;
    int exp_len[4] = '{0, 136, 48, 48};
    for (int s = 0; s < 4; s++) begin
      write_cmd(mk(17 + s, 0, 0, 0, s[0], 0, s), 0, 0, "R8 no dma");
      check("R2 resp_bits", resp_bits, exp_len[s]);
      check("R2 resp_busy", resp_busy, (s == 3) ? 1 : 0);
      check("R1 dir", xfer_dir_rd, s % 2);
      check("R1 cmd_index", cmd_index, 17 + s);
      pulse(1, 0);
      check("R5 single done", done, 1);
    end
  endtask

  task automatic t_single;
    write_cmd(mk(18, 0, 1, 1, 1, 0, 2), 5, 0, "R8 no dma");
    check("R3 single kind", xfer_kind, 1);
    check("R5 busy", busy, 1);
    check("R5 no early done", done, 0);
    pulse(1, 0);
    check("R5 done", done, 1);
    check("R5 idle", busy, 0);
    check("R7 no stop single", stop_valid, 0);
    @(negedge clk);
    check("R5 done one cycle", done, 0);
  endtask

  task automatic t_counted;
    write_cmd(mk(25, 0, 1, 1, 1, 1, 2), 3, 0, "R8 no dma");
    check("R3 multi kind", xfer_kind, 2);
    check("R4 load", blk_left, 3);
    pulse(1, 0);
    check("R4 dec1", blk_left, 2);
    check("R4 no done", done, 0);
    @(negedge clk);
    check("R4 hold without strobe", blk_left, 2);
    pulse(1, 0);
    check("R4 dec2", blk_left, 1);
    pulse(1, 0);
    check("R4 zero", blk_left, 0);
    check("R4 done", done, 1);
    check("R6 stop raised", stop_valid, 1);
    check("R6 busy during stop", busy, 1);
    @(negedge clk);
    check("R4 done one cycle", done, 0);
    @(negedge clk);
    check("R6 stop held", stop_valid, 1);
    stop_ready = 1'b1;
    @(negedge clk);
    stop_ready = 1'b0;
    check("R6 stop taken", stop_valid, 0);
    check("R6 idle after stop", busy, 0);
  endtask

  task automatic t_counted_noauto;
    write_cmd(mk(18, 0, 1, 0, 0, 1, 2), 2, 0, "R8 no dma");
    pulse(1, 0);
    pulse(1, 0);
    check("R4 done noauto", done, 1);
    check("R7 no stop noauto", stop_valid, 0);
    check("R7 idle noauto", busy, 0);
  endtask

  task automatic t_none;
    write_cmd(mk(25, 0, 1, 1, 1, 1, 1), 0, 0, "R8 no dma");
    check("R3 none kind", xfer_kind, 0);
    check("R5 none done", done, 1);
    check("R5 none not busy", busy, 0);
    @(negedge clk);
    check("R5 none done one cycle", done, 0);
  endtask

  task automatic t_infinite;
    write_cmd(mk(18, 0, 0, 1, 1, 1, 2), 7, 0, "R8 no dma");
    check("R3 inf kind", xfer_kind, 3);
    for (int i = 0; i < 3; i++) pulse(1, 0);
    check("R9 still busy", busy, 1);
    check("R9 no done", done, 0);
    pulse(0, 1);
    check("R9 abort idle", busy, 0);
    check("R9 abort no done", done, 0);
    check("R7 inf no stop", stop_valid, 0);
  endtask

  task automatic t_dma;
    write_cmd(mk(18, 1, 0, 0, 0, 0, 2), 0, 1, "R8 dma pulse");
    check("R8 dma one cycle", dma_start, 0);
    pulse(1, 0);
  endtask

  task automatic t_busy_write;
    write_cmd(mk(18, 0, 1, 0, 1, 1, 2), 4, 0, "R8 no dma");
    pulse(1, 0);
    write_cmd(mk(5, 1, 0, 0, 0, 0, 0), 9, 0, "R8 busy write no dma");
    check("R10 kind kept", xfer_kind, 2);
    check("R10 dir kept", xfer_dir_rd, 1);
    check("R10 count kept", blk_left, 3);
    pulse(0, 1);
    check("R10 busy cleared", busy, 0);
  endtask

  task automatic t_abort_last;
    write_cmd(mk(18, 0, 1, 1, 1, 1, 2), 1, 0, "R8 no dma");
    pulse(1, 1);
    check("R11 no done", done, 0);
    check("R11 no stop", stop_valid, 0);
    check("R11 idle", busy, 0);
    @(negedge clk);
    check("R11 still no stop", stop_valid, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_resp();
    t_single();
    t_counted();
    t_counted_noauto();
    t_none();
    t_infinite();
    t_dma();
    t_busy_write();
    t_abort_last();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule